// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous EDO DRAM alive and brings it up after reset. Once reset is released it waits out a long power-up pause with every strobe idle. It then runs a burst of warm-up refresh cycles on its own, with no handshake. After that it raises `init_done` and, from then on, keeps refreshes evenly spaced by making one refresh due every fixed interval. While `init_done` is low the access arbiter must not grant any accesses. During this phase the block owns the DRAM strobes outright.

After initialization, due refreshes are counted in a saturating pending counter. The block raises `ref_req` to the access arbiter and waits for `ref_grant`. While it holds the grant it drives the strobes for one complete refresh cycle, including the RAS precharge. If more refreshes are still pending at the end of precharge, it keeps `ref_req` high and starts the next one as soon as the grant is seen again. In the default mode each cycle is CAS-before-RAS: all CAS lanes fall together, RAS follows, and all strobes return high together. A parameter instead selects RAS-only refresh. In that mode CAS stays high and a row counter inside the block drives the row address. Every strobe time is a parameter in nanoseconds, turned into whole clock cycles by rounding up.

FSM states: PAUSE (power-up wait), SETUP (CAS low, RAS high), STROBE (RAS low), PRECH (RAS precharge), IDLE, WAIT (request raised, grant awaited). Transitions:
- PAUSE→first strobe state when the pause ends.
- SETUP→STROBE after the set-up count.
- STROBE→PRECH after the RAS pulse.
- PRECH→first strobe state (warm-up remaining).
- PRECH→IDLE (warm-up finished, or nothing pending).
- PRECH→WAIT (more pending).
- IDLE→WAIT (a refresh pending).
- WAIT→first strobe state on grant.

The first strobe state is SETUP in CAS-before-RAS mode and STROBE in RAS-only mode.

Top module: `dram_refresh_sched`

## Requirements
- R1: Counts are taken from the first clock edge after reset is released. For the first PAUSE_CYC = ceil(PAUSE_NS*1000/CLK_PS) edges, `ras_n` and every bit of `cas_n` stay 1, and `ref_req` and `init_done` stay 0.
- R2: After the pause, exactly WARMUP refresh cycles run back to back with `ref_req` low and `ref_grant` ignored. `init_done` rises on the edge that ends the last warm-up precharge.
- R3: With ROW_ONLY=0, all `cas_n` bits go to 0 together for CSR_CYC cycles before `ras_n` falls. They stay 0 while `ras_n` is low and return to 1 on the same edge as `ras_n`.
- R4: Each RAS pulse keeps `ras_n` at 0 for exactly RAS_CYC cycles. It is followed by at least RP_CYC cycles with `ras_n` at 1, and that precharge is part of the granted refresh.
- R5: After `init_done` rises, one refresh becomes due every INT_CYC cycles. The first one is due INT_CYC edges after the rise.
- R6: Due refreshes are counted up to PEND_MAX. Refreshes that fall due while the count is full are dropped.
- R7: After initialization, `ref_req` is 1 in WAIT, SETUP, STROBE and PRECH. It stays 1 across consecutive pending refreshes and drops only after a precharge that ends with nothing pending. Strobes move only while `ref_req` is 1.
- R8: A refresh starts on the edge at which `ref_grant` is sampled 1 in WAIT, and the pending count drops by one there. While `ref_grant` is 0 no strobe moves after initialization.
- R9: With ROW_ONLY=1, `cas_n` stays all 1s. `row_addr` starts at 0 and increases by 1 modulo 2^ROW_BITS when each RAS pulse ends. With ROW_ONLY=0, `row_addr` is 0.
- R10: Once `init_done` is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_grant | input | 1 | Arbiter grant of the DRAM to the refresh scheduler |
| ref_req | output | 1 | Refresh request to the arbiter |
| init_done | output | 1 | Power-up pause and warm-up finished; arbiter may grant accesses |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | LANES | Per-byte column strobes, active low, driven together |
| row_addr | output | ROW_BITS | Row address for RAS-only refresh, 0 otherwise |

## Verification
The bench drives a CAS-before-RAS instance and a RAS-only instance with the same grant stream. A behavioural model is compared against both on every clock.

The bench holds the grant high through initialization:
- A design that answered the grant early would strobe or raise the request before `init_done`.
- A design that miscounted the warm-up would move the `init_done` rise.

The bench withholds the grant long enough to fill the pending counter and then releases it:
- A counter that wrapped instead of saturating would produce the wrong burst length.
- A request that dropped between back-to-back refreshes would break the continuous high stretch the bench checks.

The bench also checks strobe details:
- It measures each RAS low and high run, which catches an off-by-one timer.
- It checks that CAS leads RAS by the set-up count.
- It tracks the row address of the RAS-only instance pulse by pulse, which catches an increment at the wrong time or a missing wrap.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_SETUP,
        ST_STROBE,
        ST_PRECH,
        ST_IDLE,
        ST_WAIT
    } rfs_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int cyc(input longint ns, input longint clk_ps);
        longint c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/rfs_pace.sv
module rfs_pace #(
    parameter int INT_CYC  = 780,
    parameter int PEND_MAX = 8,
    parameter int PW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          take,
    output logic [PW-1:0] pend
);
    localparam int TCW = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;

    logic [TCW-1:0] tcnt;
    logic           tick;

    assign tick = run && (tcnt == TCW'(INT_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            pend <= '0;
        end else begin
            if (run) tcnt <= tick ? '0 : tcnt + 1'b1;
            if (tick && !take && pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
            else if (!tick && take)                     pend <= pend - 1'b1;
        end
    end
endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
    import rfs_pkg::*;
#(
    parameter int ROW_ONLY  = 0,
    parameter int PAUSE_CYC = 10_000_000,
    parameter int CSR_CYC   = 1,
    parameter int RAS_CYC   = 3,
    parameter int RP_CYC    = 3,
    parameter int WARMUP    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic pend_nz,
    output logic init_done,
    output logic take,
    output logic ras_end,
    output logic ras_low,
    output logic cas_low,
    output logic req
);
    localparam int M1 = (PAUSE_CYC > CSR_CYC) ? PAUSE_CYC : CSR_CYC;
    localparam int M2 = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
    localparam int MX = (M1 > M2) ? M1 : M2;
    localparam int TW = $clog2(MX + 1);
    localparam int WW = $clog2(WARMUP + 1);
    localparam rfs_state_e FIRST_ST = (ROW_ONLY != 0) ? ST_STROBE : ST_SETUP;
    localparam logic [TW-1:0] FIRST_LD = TW'(((ROW_ONLY != 0) ? RAS_CYC : CSR_CYC) - 1);

    rfs_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [WW-1:0] warm_q, warm_d;
    logic          done_q, done_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            tmr_q   <= TW'(PAUSE_CYC - 1);
            warm_q  <= WW'(WARMUP);
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            warm_q  <= warm_d;
            done_q  <= done_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        warm_d  = warm_q;
        done_d  = done_q;
        take    = 1'b0;
        ras_end = 1'b0;
        unique case (state_q)
            ST_PAUSE: begin
                if (tmr_q == '0) begin
                    state_d = FIRST_ST;
                    tmr_d   = FIRST_LD;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_q == '0) begin
                    state_d = ST_STROBE;
                    tmr_d   = TW'(RAS_CYC - 1);
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (tmr_q == '0) begin
                    state_d = ST_PRECH;
                    tmr_d   = TW'(RP_CYC - 1);
                    ras_end = 1'b1;
                    if (!done_q) warm_d = warm_q - 1'b1;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            ST_PRECH: begin
                if (tmr_q == '0) begin
                    if (!done_q) begin
                        if (warm_q == '0) begin
                            state_d = ST_IDLE;
                            done_d  = 1'b1;
                        end else begin
                            state_d = FIRST_ST;
                            tmr_d   = FIRST_LD;
                        end
                    end else begin
                        state_d = pend_nz ? ST_WAIT : ST_IDLE;
                    end
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            ST_IDLE: begin
                if (done_q && pend_nz) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (gnt) begin
                    take    = 1'b1;
                    state_d = FIRST_ST;
                    tmr_d   = FIRST_LD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        init_done = done_q;
        ras_low   = (state_q == ST_STROBE);
        cas_low   = (ROW_ONLY == 0) && (state_q == ST_SETUP || state_q == ST_STROBE);
        req       = done_q && (state_q == ST_WAIT || state_q == ST_SETUP ||
                               state_q == ST_STROBE || state_q == ST_PRECH);
    end
endmodule

// File: rtl/rfs_rowctr.sv
module rfs_rowctr #(
    parameter int ROW_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [ROW_BITS-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfs_pkg::*;
#(
    parameter int CLK_PS      = 20000,
    parameter int PAUSE_NS    = 200_000_000,
    parameter int CSR_NS      = 10,
    parameter int RAS_NS      = 45,
    parameter int RP_NS       = 49,
    parameter int INTERVAL_NS = 15600,
    parameter int WARMUP      = 8,
    parameter int PEND_MAX    = 8,
    parameter int ROW_BITS    = 9,
    parameter int LANES       = 4,
    parameter int ROW_ONLY    = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_grant,
    output logic                ref_req,
    output logic                init_done,
    output logic                ras_n,
    output logic [LANES-1:0]    cas_n,
    output logic [ROW_BITS-1:0] row_addr
);
    localparam int PAUSE_CYC = cyc(PAUSE_NS, CLK_PS);
    localparam int CSR_CYC   = cyc(CSR_NS, CLK_PS);
    localparam int RAS_CYC   = cyc(RAS_NS, CLK_PS);
    localparam int RP_CYC    = cyc(RP_NS, CLK_PS);
    localparam int INT_CYC   = cyc(INTERVAL_NS, CLK_PS);
    localparam int PW        = $clog2(PEND_MAX + 1);

    logic [PW-1:0]       pend_cnt;
    logic                take, ras_end, ras_low, cas_low;
    logic [ROW_BITS-1:0] row_q;

    rfs_pace #(.INT_CYC(INT_CYC), .PEND_MAX(PEND_MAX), .PW(PW)) u_pace (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (init_done),
        .take (take),
        .pend (pend_cnt)
    );

    rfs_seq #(
        .ROW_ONLY(ROW_ONLY), .PAUSE_CYC(PAUSE_CYC), .CSR_CYC(CSR_CYC),
        .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC), .WARMUP(WARMUP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt      (ref_grant),
        .pend_nz  (pend_cnt != '0),
        .init_done(init_done),
        .take     (take),
        .ras_end  (ras_end),
        .ras_low  (ras_low),
        .cas_low  (cas_low),
        .req      (ref_req)
    );

    rfs_rowctr #(.ROW_BITS(ROW_BITS)) u_row (
        .clk  (clk),
        .rst_n(rst_n),
        .step (ras_end),
        .row  (row_q)
    );

    assign ras_n    = ~ras_low;
    assign row_addr = (ROW_ONLY != 0) ? row_q : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cas_n[g] = ~cas_low;
    end
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int ROW_ONLY = 0,
    parameter int RAS_CYC  = 3,
    parameter int RP_CYC   = 3,
    parameter int PEND_MAX = 8,
    parameter int LANES    = 4,
    parameter int PW       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             ref_req,
    input logic             init_done,
    input logic [PW-1:0]    pend
);
    int low_len, high_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len  <= 0;
            high_len <= 0;
        end else if (!ras_n) begin
            low_len  <= low_len + 1;
            high_len <= 0;
        end else begin
            low_len  <= 0;
            if (high_len < 32'h7fff_0000) high_len <= high_len + 1;
        end
    end

    a_r1_no_req_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (ROW_ONLY == 0) && $fell(ras_n) |-> $past(cas_n) == '0);
    a_r3_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ROW_ONLY == 0) && !ras_n |-> cas_n == '0);
    a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> low_len == RAS_CYC);
    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> high_len >= RP_CYC);
    a_r6_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(PEND_MAX));
    a_r7_strobes_need_req: assert property (@(posedge clk) disable iff (!rst_n)
        init_done && (!ras_n || cas_n != '1) |-> ref_req);
    a_r9_rowonly_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ROW_ONLY != 0) |-> cas_n == '1);
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind dram_refresh_sched rfs_checker #(
    .ROW_ONLY(ROW_ONLY), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .PEND_MAX(PEND_MAX), .LANES(LANES), .PW(PW)
) u_rfs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ref_req  (ref_req),
    .init_done(init_done),
    .pend     (pend_cnt)
);

// File: tb/test_model.sv
module test_model #(
    parameter int ROW_ONLY = 0,
    parameter int PAUSE    = 100,
    parameter int CSR      = 1,
    parameter int RASW     = 3,
    parameter int RP       = 3,
    parameter int WARM     = 8,
    parameter int INTV     = 50,
    parameter int PMAX     = 8,
    parameter int ROWS     = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    output logic e_ras_n,
    output logic e_cas_low,
    output logic e_req,
    output logic e_done,
    output int   e_row
);
    // phase: 0 pause, 1 cas lead, 2 ras low, 3 precharge, 4 idle, 5 waiting
    int phase, left, warm, pend, tick, row, op;
    bit done, od, tk, tok;

    task automatic begin_refresh();
        if (ROW_ONLY != 0) begin phase = 2; left = RASW; end
        else               begin phase = 1; left = CSR;  end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0; left = PAUSE; warm = WARM; pend = 0; tick = 0; row = 0; done = 0;
        end else begin
            od = done; op = pend; tok = 0;
            if (phase <= 3) begin
                left = left - 1;
                if (left == 0) begin
                    if (phase == 0) begin_refresh();
                    else if (phase == 1) begin phase = 2; left = RASW; end
                    else if (phase == 2) begin
                        phase = 3; left = RP;
                        row = (row + 1) % ROWS;
                        if (!od) warm = warm - 1;
                    end else begin
                        if (!od) begin
                            if (warm == 0) begin phase = 4; done = 1; end
                            else begin_refresh();
                        end else phase = (op > 0) ? 5 : 4;
                    end
                end
            end else if (phase == 4) begin
                if (od && op > 0) phase = 5;
            end else if (gnt) begin
                tok = 1;
                begin_refresh();
            end
            tk = od && (tick == INTV - 1);
            if (od) tick = tk ? 0 : tick + 1;
            pend = op - int'(tok) + int'(tk);
            if (pend > PMAX) pend = PMAX;
        end
    end

    assign e_ras_n   = !(phase == 2);
    assign e_cas_low = (ROW_ONLY == 0) && (phase == 1 || phase == 2);
    assign e_req     = done && (phase == 1 || phase == 2 || phase == 3 || phase == 5);
    assign e_done    = done;
    assign e_row     = (ROW_ONLY != 0) ? row : 0;
endmodule

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    always #10 clk = ~clk;

    logic       c_req, c_done, c_ras_n;
    logic [3:0] c_cas_n;
    logic [8:0] c_row;
    logic       r_req, r_done, r_ras_n;
    logic [3:0] r_cas_n;
    logic [8:0] r_row;

    dram_refresh_sched #(.CLK_PS(20000), .PAUSE_NS(2000), .INTERVAL_NS(1000), .ROW_ONLY(0))
    i_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ref_grant(gnt), .ref_req(c_req), .init_done(c_done),
        .ras_n(c_ras_n), .cas_n(c_cas_n), .row_addr(c_row));

    dram_refresh_sched #(.CLK_PS(20000), .PAUSE_NS(2000), .INTERVAL_NS(1000), .ROW_ONLY(1))
    i_dram_refresh_sched_rowonly (
        .clk(clk), .rst_n(rst_n), .ref_grant(gnt), .ref_req(r_req), .init_done(r_done),
        .ras_n(r_ras_n), .cas_n(r_cas_n), .row_addr(r_row));

    logic m_ras_n, m_cas_low, m_req, m_done, n_ras_n, n_cas_low, n_req, n_done;
    int   m_row, n_row;
    test_model #(.ROW_ONLY(0)) u_mc (.clk(clk), .rst_n(rst_n), .gnt(gnt), .e_ras_n(m_ras_n),
        .e_cas_low(m_cas_low), .e_req(m_req), .e_done(m_done), .e_row(m_row));
    test_model #(.ROW_ONLY(1)) u_mr (.clk(clk), .rst_n(rst_n), .gnt(gnt), .e_ras_n(n_ras_n),
        .e_cas_low(n_cas_low), .e_req(n_req), .e_done(n_done), .e_row(n_row));

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;
    bit compare_on = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference model and independent strobe checks
    int  c_falls = 0, c_low = 0, c_high = 0, next_row = 0;
    bit  c_prev = 1'b1, r_prev = 1'b1;
    always @(negedge clk) begin
        if (compare_on) begin
            check("R4 cbr ras_n", c_ras_n, m_ras_n);
            check("R3 cbr cas_n", c_cas_n, m_cas_low ? 4'h0 : 4'hF);
            check("R7 cbr ref_req", c_req, m_req);
            check("R10 cbr init_done", c_done, m_done);
            check("R9 cbr row_addr", c_row, m_row);
            check("R4 ro ras_n", r_ras_n, n_ras_n);
            check("R9 ro cas_n", r_cas_n, n_cas_low ? 4'h0 : 4'hF);
            check("R7 ro ref_req", r_req, n_req);
            check("R10 ro init_done", r_done, n_done);
            check("R9 ro row_addr", r_row, n_row);
            if (c_prev && !c_ras_n) begin
                c_falls++;
                if (c_high < 3) check("R4 precharge length", c_high, 3);
                c_low = 0;
            end
            if (!c_prev && c_ras_n) begin
                check("R4 ras low length", c_low, 3);
                c_high = 0;
            end
            if (!c_ras_n) c_low++; else c_high++;
            if (r_prev && !r_ras_n) begin
                check("R9 row sequence", r_row, next_row);
                next_row = (next_row + 1) % 512;
            end
            c_prev = c_ras_n;
            r_prev = r_ras_n;
        end
    end

    initial begin
        int first_ras, first_cas, c_init, r_init, f0;
        bit req_ok;
        logic [15:0] lfsr;
        first_ras = 0; first_cas = 0; c_init = 0; r_init = 0;
        gnt = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset ras_n", {c_ras_n, r_ras_n}, 2'b11);
        check("R1 reset cas_n", {c_cas_n, r_cas_n}, 8'hFF);
        check("R1 reset ref_req", {c_req, r_req}, 2'b00);
        check("R1 reset init_done", {c_done, r_done}, 2'b00);
        rst_n = 1'b1;
        compare_on = 1'b1;
        // grant is held high throughout init: it must be ignored (R2)
        for (int n = 1; n <= 400 && c_init == 0; n++) begin
            @(negedge clk);
            if (!c_ras_n && first_ras == 0) first_ras = n;
            if (c_cas_n == 4'h0 && first_cas == 0) first_cas = n;
            if (r_done && r_init == 0) r_init = n;
            if (c_done) c_init = n;
        end
        check("R1 pause length, first CAS", first_cas, 100);
        check("R3 CAS leads RAS by one cycle", first_ras, 101);
        check("R2 init_done after 8 CBR warm-ups", c_init, 156);
        check("R2 init_done after 8 RAS-only warm-ups", r_init, 148);

        // R5: grant always on, one refresh every 50 cycles
        @(posedge clk); f0 = c_falls;
        repeat (410) @(posedge clk);
        check("R5 refreshes in 410 cycles", c_falls - f0, 8);

        // R8: grant withheld, nothing moves; pending saturates (R6)
        @(negedge clk); gnt = 1'b0;
        repeat (20) @(posedge clk);
        f0 = c_falls;
        repeat (700) @(posedge clk);
        check("R8 no refresh without grant", c_falls - f0, 0);
        @(negedge clk); gnt = 1'b1;
        req_ok = 1'b1;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (!c_req) req_ok = 1'b0;
        end
        check("R6 req held through saturated backlog", req_ok, 1);

        // mixed grant pattern
        lfsr = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            gnt = lfsr[0] & lfsr[5];
        end
        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule